// File: doc/BRIEF.md
# Multi-Channel Sound Playback Controller

This block sequences a bank of sound playback channels (16 by default). Each channel holds a playback state, an assigned sound number, a sound length, a loop setting and a running sample position. Software reaches the block through a flat register port: it picks a channel with the channel-select register, writes that channel's settings, and issues commands through the command register. Single-channel commands act only on the selected channel. Global commands act on every channel in the same write. A one-cycle `sample_tick` pulse, nominally at 44.1 kHz (735 pulses per 60 Hz frame), moves every playing channel forward by one sample.

Each channel runs a three-state machine. The states are Stopped, Paused and Playing, and they are read back as 0x40, 0x41 and 0x42. Its transitions are:
- START (Stopped to Playing, position 0).
- RETRIGGER (Playing to Playing, position 0).
- RESUME (Paused to Playing, position kept).
- HOLD (Playing to Paused).
- HALT (any state to Stopped, position 0).
- FINISH (Playing to Stopped at the end of the sound, position 0).
- WRAP (Playing to Playing at the end of the sound, position set to the loop start).

Register writes take effect at the clock edge. Reads are combinational from the registered state of the selected channel. Sample memory, mixing, volume and the audio output sit outside this block; they consume the state and position it maintains.

Top module: `snd_chan_ctrl`

## Requirements
- R1: After reset every channel reads Stopped (0x40) at position 0, and the channel-select register reads 0.
- R2: Register offsets are as follows. Command at 0x00 (write). Channel select at 0x03. Length at 0x04, loop start at 0x06, sound number at 0x09 and loop enable at 0x0C (bit 0); these four apply to the selected channel and read back. State at 0x08 and position at 0x0D (read). State codes are Stopped 0x40, Paused 0x41 and Playing 0x42.
- R3: Command 0x30 on a Stopped channel makes it Playing at position 0, and each `sample_tick` then adds 1 to its position.
- R4: Command 0x30 on a Paused channel resumes it from its held position. On a Playing channel it restarts playback at position 0.
- R5: Command 0x31 turns a Playing channel into Paused and has no effect in any other state. A Paused channel's position does not change on ticks.
- R6: Command 0x32 makes the selected channel Stopped at position 0 from any state.
- R7: In a single write, 0x33 pauses every Playing channel, 0x34 resumes only the Paused channels (Stopped channels stay Stopped), and 0x35 stops every channel at position 0.
- R8: A tick on a Playing channel whose position plus one is at least its length, with loop enable 0, makes the channel Stopped at position 0.
- R9: In the same end-of-sound case with loop enable 1, the position becomes the loop start and the channel stays Playing.
- R10: Command values other than 0x30–0x35 change nothing, and writes of 16 or more to the channel-select register are ignored.
- R11: When a command and a tick arrive in the same cycle, the command alone decides the affected channel's next state and position.
- R12: Settings are kept per channel: writing one channel's settings leaves every other channel's settings unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle pulse per output sample |
| io_wr | input | 1 | Register write strobe |
| io_waddr | input | 8 | Register write offset |
| io_wdata | input | 32 | Register write data |
| io_raddr | input | 8 | Register read offset |
| io_rdata | output | 32 | Register read data for the selected channel |

## Verification
The state machine is driven from each state with each command, so that resume, retrigger and restart-from-stopped are separated by the position that follows. Ticks are applied across the end of a short sound with looping off and with looping on; this separates the finish from the wrap and checks the exact end point. A mix of Playing, Paused and Stopped channels then receives the global commands, which shows whether resume-all is correctly limited to Paused channels. Collisions of commands with ticks, and out-of-range commands and selects, confirm the priority and that those writes change nothing.

// File: rtl/snd_pkg.sv
package snd_pkg;

    typedef enum logic [7:0] {
        CH_STOPPED = 8'h40,
        CH_PAUSED  = 8'h41,
        CH_PLAYING = 8'h42
    } ch_state_e;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PLAY,
        OP_PAUSE,
        OP_STOP,
        OP_PAUSE_ALL,
        OP_RESUME_ALL,
        OP_STOP_ALL
    } ctl_op_e;

    localparam logic [7:0] CMD_PLAY       = 8'h30;
    localparam logic [7:0] CMD_PAUSE      = 8'h31;
    localparam logic [7:0] CMD_STOP       = 8'h32;
    localparam logic [7:0] CMD_PAUSE_ALL  = 8'h33;
    localparam logic [7:0] CMD_RESUME_ALL = 8'h34;
    localparam logic [7:0] CMD_STOP_ALL   = 8'h35;

    localparam logic [7:0] REG_CMD   = 8'h00;
    localparam logic [7:0] REG_SEL   = 8'h03;
    localparam logic [7:0] REG_LEN   = 8'h04;
    localparam logic [7:0] REG_START = 8'h06;
    localparam logic [7:0] REG_STATE = 8'h08;
    localparam logic [7:0] REG_SND   = 8'h09;
    localparam logic [7:0] REG_LOOP  = 8'h0C;
    localparam logic [7:0] REG_POS   = 8'h0D;

endpackage

// File: rtl/snd_cmd_decode.sv
module snd_cmd_decode
    import snd_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int SEL_W = 4,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr_i,
    input  logic [DW-1:0]    cmd_val_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic [NCH-1:0]   play_o,
    output logic [NCH-1:0]   pause_o,
    output logic [NCH-1:0]   stop_o,
    output logic [NCH-1:0]   resume_o
);

    ctl_op_e        op;
    logic [NCH-1:0] sel_oh;

    always_comb begin
        op = OP_NONE;
        if (cmd_wr_i && (cmd_val_i[DW-1:8] == '0)) begin
            unique case (cmd_val_i[7:0])
                CMD_PLAY:       op = OP_PLAY;
                CMD_PAUSE:      op = OP_PAUSE;
                CMD_STOP:       op = OP_STOP;
                CMD_PAUSE_ALL:  op = OP_PAUSE_ALL;
                CMD_RESUME_ALL: op = OP_RESUME_ALL;
                CMD_STOP_ALL:   op = OP_STOP_ALL;
                default:        op = OP_NONE;
            endcase
        end
    end

    always_comb begin
        sel_oh        = '0;
        sel_oh[sel_i] = 1'b1;
    end

    always_comb begin
        play_o   = '0;
        pause_o  = '0;
        stop_o   = '0;
        resume_o = '0;
        unique case (op)
            OP_PLAY:       play_o   = sel_oh;
            OP_PAUSE:      pause_o  = sel_oh;
            OP_STOP:       stop_o   = sel_oh;
            OP_PAUSE_ALL:  pause_o  = '1;
            OP_RESUME_ALL: resume_o = '1;
            OP_STOP_ALL:   stop_o   = '1;
            default:       ;
        endcase
    end

    AST_BAD_CMD_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && ((cmd_val_i < DW'(CMD_PLAY)) || (cmd_val_i > DW'(CMD_STOP_ALL))))
        |-> (play_o == '0 && pause_o == '0 && stop_o == '0 && resume_o == '0)); // R10

    AST_PLAY_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(play_o)); // R4

    AST_STOP_ALL_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr_i && cmd_val_i == DW'(CMD_STOP_ALL)) |-> (stop_o == '1)); // R7

endmodule

// File: rtl/snd_channel.sv
module snd_channel
    import snd_pkg::*;
#(
    parameter int POS_W = 24,
    parameter int SND_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             act_play_i,
    input  logic             act_pause_i,
    input  logic             act_stop_i,
    input  logic             act_resume_i,
    input  logic             wr_len_i,
    input  logic             wr_start_i,
    input  logic             wr_loop_i,
    input  logic             wr_snd_i,
    input  logic [POS_W-1:0] wdata_pos_i,
    input  logic [SND_W-1:0] wdata_snd_i,
    input  logic             wdata_flag_i,
    output ch_state_e        state_o,
    output logic [POS_W-1:0] pos_o,
    output logic [POS_W-1:0] len_o,
    output logic [POS_W-1:0] start_o,
    output logic             loop_o,
    output logic [SND_W-1:0] snd_o
);

    ch_state_e        st_q, st_d;
    logic [POS_W-1:0] pos_q, pos_d;
    logic [POS_W-1:0] len_q, start_q;
    logic             loop_q;
    logic [SND_W-1:0] snd_q;
    logic             at_end;
    logic             any_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q   <= '0;
            start_q <= '0;
            loop_q  <= 1'b0;
            snd_q   <= '0;
        end else begin
            if (wr_len_i)   len_q   <= wdata_pos_i;
            if (wr_start_i) start_q <= wdata_pos_i;
            if (wr_loop_i)  loop_q  <= wdata_flag_i;
            if (wr_snd_i)   snd_q   <= wdata_snd_i;
        end
    end

    assign at_end  = ({1'b0, pos_q} + {{POS_W{1'b0}}, 1'b1}) >= {1'b0, len_q};
    assign any_act = act_play_i | act_pause_i | act_stop_i | act_resume_i;

    always_comb begin
        st_d  = st_q;
        pos_d = pos_q;
        if (act_stop_i) begin
            st_d  = CH_STOPPED;
            pos_d = '0;
        end else if (act_play_i) begin
            unique case (st_q)
                CH_PAUSED: st_d = CH_PLAYING;
                CH_STOPPED, CH_PLAYING: begin
                    st_d  = CH_PLAYING;
                    pos_d = '0;
                end
                default: begin
                    st_d  = CH_STOPPED;
                    pos_d = '0;
                end
            endcase
        end else if (act_resume_i) begin
            if (st_q == CH_PAUSED) st_d = CH_PLAYING;
        end else if (act_pause_i) begin
            if (st_q == CH_PLAYING) st_d = CH_PAUSED;
        end else if (tick_i) begin
            unique case (st_q)
                CH_PLAYING: begin
                    if (!at_end) begin
                        pos_d = pos_q + POS_W'(1);
                    end else if (loop_q) begin
                        pos_d = start_q;
                    end else begin
                        st_d  = CH_STOPPED;
                        pos_d = '0;
                    end
                end
                CH_PAUSED, CH_STOPPED: ;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= CH_STOPPED;
            pos_q <= '0;
        end else begin
            st_q  <= st_d;
            pos_q <= pos_d;
        end
    end

    always_comb begin
        state_o = st_q;
        pos_o   = pos_q;
        len_o   = len_q;
        start_o = start_q;
        loop_o  = loop_q;
        snd_o   = snd_q;
    end

    AST_STOPPED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_STOPPED) |-> (pos_q == '0)); // R6

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_PAUSED && !act_play_i && !act_resume_i && !act_stop_i)
        |=> (st_q == CH_PAUSED && $stable(pos_q))); // R5

    AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_PLAYING && tick_i && !any_act && !at_end)
        |=> (st_q == CH_PLAYING && pos_q == POS_W'($past(pos_q) + 1'b1))); // R3

    AST_LOOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_PLAYING && tick_i && !any_act && at_end && loop_q)
        |=> (st_q == CH_PLAYING && pos_q == $past(start_q))); // R9

    AST_RETRIGGER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_PLAYING && act_play_i && !act_stop_i)
        |=> (st_q == CH_PLAYING && pos_q == '0)); // R4

endmodule

// File: rtl/snd_chan_ctrl.sv
module snd_chan_ctrl
    import snd_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int POS_W = 24,
    parameter int SND_W = 10,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_tick,
    input  logic          io_wr,
    input  logic [AW-1:0] io_waddr,
    input  logic [DW-1:0] io_wdata,
    input  logic [AW-1:0] io_raddr,
    output logic [DW-1:0] io_rdata
);

    localparam int SEL_W = $clog2(NCH);

    logic [SEL_W-1:0] sel_q;
    logic             wr_cmd, wr_sel, wr_len, wr_start, wr_loop, wr_snd;
    logic [NCH-1:0]   act_play, act_pause, act_stop, act_resume;

    ch_state_e        st_a    [NCH];
    logic [POS_W-1:0] pos_a   [NCH];
    logic [POS_W-1:0] len_a   [NCH];
    logic [POS_W-1:0] start_a [NCH];
    logic             loop_a  [NCH];
    logic [SND_W-1:0] snd_a   [NCH];

    assign wr_cmd   = io_wr && (io_waddr == AW'(REG_CMD));
    assign wr_sel   = io_wr && (io_waddr == AW'(REG_SEL));
    assign wr_len   = io_wr && (io_waddr == AW'(REG_LEN));
    assign wr_start = io_wr && (io_waddr == AW'(REG_START));
    assign wr_loop  = io_wr && (io_waddr == AW'(REG_LOOP));
    assign wr_snd   = io_wr && (io_waddr == AW'(REG_SND));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_sel && (io_wdata < DW'(NCH))) begin
            sel_q <= io_wdata[SEL_W-1:0];
        end
    end

    snd_cmd_decode #(
        .NCH   (NCH),
        .SEL_W (SEL_W),
        .DW    (DW)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr_i  (wr_cmd),
        .cmd_val_i (io_wdata),
        .sel_i     (sel_q),
        .play_o    (act_play),
        .pause_o   (act_pause),
        .stop_o    (act_stop),
        .resume_o  (act_resume)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = (sel_q == SEL_W'(g));

        snd_channel #(
            .POS_W (POS_W),
            .SND_W (SND_W)
        ) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick_i       (sample_tick),
            .act_play_i   (act_play[g]),
            .act_pause_i  (act_pause[g]),
            .act_stop_i   (act_stop[g]),
            .act_resume_i (act_resume[g]),
            .wr_len_i     (wr_len && hit),
            .wr_start_i   (wr_start && hit),
            .wr_loop_i    (wr_loop && hit),
            .wr_snd_i     (wr_snd && hit),
            .wdata_pos_i  (io_wdata[POS_W-1:0]),
            .wdata_snd_i  (io_wdata[SND_W-1:0]),
            .wdata_flag_i (io_wdata[0]),
            .state_o      (st_a[g]),
            .pos_o        (pos_a[g]),
            .len_o        (len_a[g]),
            .start_o      (start_a[g]),
            .loop_o       (loop_a[g]),
            .snd_o        (snd_a[g])
        );
    end

    always_comb begin
        io_rdata = '0;
        unique case (io_raddr)
            AW'(REG_SEL):   io_rdata = DW'(sel_q);
            AW'(REG_LEN):   io_rdata = DW'(len_a[sel_q]);
            AW'(REG_START): io_rdata = DW'(start_a[sel_q]);
            AW'(REG_STATE): io_rdata = DW'(st_a[sel_q]);
            AW'(REG_SND):   io_rdata = DW'(snd_a[sel_q]);
            AW'(REG_LOOP):  io_rdata = DW'(loop_a[sel_q]);
            AW'(REG_POS):   io_rdata = DW'(pos_a[sel_q]);
            default:        io_rdata = '0;
        endcase
    end

    AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (io_wdata >= DW'(NCH))) |=> $stable(sel_q)); // R10

    AST_SEL_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (io_wdata < DW'(NCH))) |=> (sel_q == $past(io_wdata[SEL_W-1:0]))); // R2

endmodule

// File: tb/snd_chan_ctrl_bench.sv
module snd_chan_ctrl_bench;

    localparam logic [7:0] A_CMD = 8'h00, A_SEL = 8'h03, A_LEN = 8'h04, A_START = 8'h06;
    localparam logic [7:0] A_STATE = 8'h08, A_SND = 8'h09, A_LOOP = 8'h0C, A_POS = 8'h0D;
    localparam logic [31:0] S_STOP = 32'h40, S_PAUSE = 32'h41, S_PLAY = 32'h42;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_tick = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_waddr = '0;
    logic [31:0] io_wdata = '0;
    logic [7:0]  io_raddr = '0;
    logic [31:0] io_rdata;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    snd_chan_ctrl u_snd_chan_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .io_wr       (io_wr),
        .io_waddr    (io_waddr),
        .io_wdata    (io_wdata),
        .io_raddr    (io_raddr),
        .io_rdata    (io_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_waddr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sample_tick = 1'b1;
            @(negedge clk);
            sample_tick = 1'b0;
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        io_raddr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic chk_ch(input int ch, input logic [31:0] st, input logic [31:0] pos, input string req);
        logic [31:0] v;
        wr(A_SEL, ch);
        rd(A_STATE, v); chk({req, " state"}, v, st);
        rd(A_POS, v);   chk({req, " position"}, v, pos);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_SEL, v); chk("R1 select", v, 0);
        rd(A_STATE, v); chk("R1 state ch0", v, S_STOP);
        rd(A_POS, v); chk("R1 pos ch0", v, 0);
        chk_ch(15, S_STOP, 0, "R1 ch15");
    endtask

    task automatic t_play_stop;
        wr(A_CMD, 32'h35);
        wr(A_SEL, 2); wr(A_LEN, 10); wr(A_CMD, 32'h30);
        chk_ch(2, S_PLAY, 0, "R3 start");
        ticks(3);
        chk_ch(2, S_PLAY, 3, "R3 advance");
        wr(A_CMD, 32'h32);
        chk_ch(2, S_STOP, 0, "R6 stop");
    endtask

    task automatic t_pause_resume;
        wr(A_CMD, 32'h35);
        wr(A_SEL, 4); wr(A_LEN, 20); wr(A_CMD, 32'h30);
        ticks(4);
        wr(A_CMD, 32'h31);
        chk_ch(4, S_PAUSE, 4, "R5 pause");
        ticks(3);
        chk_ch(4, S_PAUSE, 4, "R5 frozen");
        wr(A_CMD, 32'h30);
        chk_ch(4, S_PLAY, 4, "R4 resume");
        ticks(1);
        chk_ch(4, S_PLAY, 5, "R4 resumed advance");
        wr(A_CMD, 32'h30);
        chk_ch(4, S_PLAY, 0, "R4 retrigger");
        wr(A_CMD, 32'h32);
        wr(A_CMD, 32'h31);
        chk_ch(4, S_STOP, 0, "R5 pause on stopped");
        wr(A_CMD, 32'h30); ticks(2); wr(A_CMD, 32'h31);
        wr(A_CMD, 32'h32);
        chk_ch(4, S_STOP, 0, "R6 stop from paused");
    endtask

    task automatic t_end_noloop;
        wr(A_CMD, 32'h35);
        wr(A_SEL, 6); wr(A_LEN, 3); wr(A_LOOP, 0); wr(A_CMD, 32'h30);
        ticks(2);
        chk_ch(6, S_PLAY, 2, "R8 last sample");
        ticks(1);
        chk_ch(6, S_STOP, 0, "R8 finish");
    endtask

    task automatic t_loop;
        wr(A_CMD, 32'h35);
        wr(A_SEL, 7); wr(A_LEN, 5); wr(A_START, 2); wr(A_LOOP, 1); wr(A_CMD, 32'h30);
        ticks(4);
        chk_ch(7, S_PLAY, 4, "R9 before wrap");
        ticks(1);
        chk_ch(7, S_PLAY, 2, "R9 wrap");
        ticks(1);
        chk_ch(7, S_PLAY, 3, "R9 after wrap");
    endtask

    task automatic t_global;
        wr(A_CMD, 32'h35);
        wr(A_SEL, 0); wr(A_LEN, 100); wr(A_LOOP, 0); wr(A_CMD, 32'h30);
        wr(A_SEL, 1); wr(A_LEN, 100); wr(A_LOOP, 0); wr(A_CMD, 32'h30);
        ticks(2);
        wr(A_CMD, 32'h31);
        ticks(1);
        wr(A_SEL, 2); wr(A_LEN, 100);
        wr(A_CMD, 32'h33);
        ticks(1);
        chk_ch(0, S_PAUSE, 3, "R7 pause-all ch0");
        chk_ch(1, S_PAUSE, 2, "R7 pause-all ch1");
        chk_ch(2, S_STOP, 0, "R7 pause-all ch2");
        wr(A_CMD, 32'h34);
        chk_ch(0, S_PLAY, 3, "R7 resume-all ch0");
        chk_ch(1, S_PLAY, 2, "R7 resume-all ch1");
        chk_ch(2, S_STOP, 0, "R7 resume-all ch2");
        ticks(1);
        chk_ch(0, S_PLAY, 4, "R7 resumed ch0");
        wr(A_CMD, 32'h35);
        chk_ch(0, S_STOP, 0, "R7 stop-all ch0");
        chk_ch(1, S_STOP, 0, "R7 stop-all ch1");
    endtask

    task automatic t_invalid;
        logic [31:0] v;
        wr(A_CMD, 32'h35);
        wr(A_SEL, 5); wr(A_LEN, 50); wr(A_CMD, 32'h30);
        ticks(2);
        wr(A_CMD, 32'h36); wr(A_CMD, 32'h2F); wr(A_CMD, 32'h00); wr(A_CMD, 32'h132);
        rd(A_STATE, v); chk("R10 bad cmd state", v, S_PLAY);
        rd(A_POS, v);   chk("R10 bad cmd pos", v, 2);
        wr(A_SEL, 16);
        rd(A_SEL, v); chk("R10 select 16", v, 5);
        wr(A_SEL, 32'hFFFF);
        rd(A_SEL, v); chk("R10 select large", v, 5);
    endtask

    task automatic t_collide;
        wr(A_CMD, 32'h35);
        wr(A_SEL, 9); wr(A_LEN, 40); wr(A_CMD, 32'h30);
        ticks(3);
        @(negedge clk);
        io_wr = 1'b1; io_waddr = A_CMD; io_wdata = 32'h31; sample_tick = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; sample_tick = 1'b0;
        chk_ch(9, S_PAUSE, 3, "R11 pause with tick");
        @(negedge clk);
        io_wr = 1'b1; io_waddr = A_CMD; io_wdata = 32'h30; sample_tick = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; sample_tick = 1'b0;
        chk_ch(9, S_PLAY, 3, "R11 resume with tick");
    endtask

    task automatic t_settings;
        logic [31:0] v;
        wr(A_SEL, 3); wr(A_SND, 7);  wr(A_LEN, 123); wr(A_START, 11); wr(A_LOOP, 1);
        wr(A_SEL, 4); wr(A_SND, 9);  wr(A_LEN, 456); wr(A_START, 22); wr(A_LOOP, 0);
        wr(A_SEL, 3);
        rd(A_SND, v);   chk("R12 ch3 sound", v, 7);
        rd(A_LEN, v);   chk("R12 ch3 length", v, 123);
        rd(A_START, v); chk("R2 ch3 loop start", v, 11);
        rd(A_LOOP, v);  chk("R2 ch3 loop enable", v, 1);
        wr(A_SEL, 4);
        rd(A_SND, v);   chk("R12 ch4 sound", v, 9);
        rd(A_LEN, v);   chk("R12 ch4 length", v, 456);
        rd(A_SEL, v);   chk("R2 select readback", v, 4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_play_stop();
        t_pause_resume();
        t_end_noloop();
        t_loop();
        t_global();
        t_invalid();
        t_collide();
        t_settings();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule